// File: doc/BRIEF.md
# IDE Programmed-I/O Cycle Timer

This block produces the read and write strobes of programmed-I/O transfers on an IDE port. Each transfer has an active phase, with the strobe asserted, and a recovery phase, with the strobe released. Both phases are counted in local-bus clocks. The host programs the phase lengths through a byte-wide register port. That port holds two timing registers, a read-only configuration register and a control register. A timing byte keeps the active field in its low nibble and the recovery field in its high nibble. Both fields are stored as inverted, offset counts.

The decode of a timing byte depends on the build variant. In the dual-channel variant, a control bit selects which timing register times which drive. In the single-channel variant, one timing register times every transfer, and a bus-speed strap selects one of two decode tables.

To start a transfer, the requester raises a request with a channel, a drive and a direction. The block then drives the strobe, releases it, and gives a one-cycle completion pulse when recovery ends.

Top module: `ide_pio_strobe_timer`

## Requirements
- R1: After reset, timing registers read 0x00 in the dual variant and 0x08 in the single variant, the control register reads 0x0F, no strobe is asserted and busy is low.
- R2: A byte written to a timing register (offset 0, or offset 2 in the dual variant) reads back unchanged.
- R3: Offset 1 reads {identity[7:4], bit3, strap[2], 2'b00}. The identity is 1010 for dual and 1100 for single. Bit 3 is 1 for dual and 0 for single. Bit 2 follows the busSlow input. Writes to offset 1 have no effect.
- R4: Dual variant: active cycles = 17 − low nibble. Recovery cycles = 15 − high nibble, with a floor of 2.
- R5: Single variant, using only bits 2:0 of the low nibble: with busSlow=1, active = 9 − field and recovery = 15 − high nibble. With busSlow=0, active = 8 − field and recovery = 18 − high nibble.
- R6: Dual variant, control bit 0 = 1: drive 0 uses offset 0 and drive 1 uses offset 2, whatever the channel. Control bit 0 = 0: channel 0 uses offset 0 and channel 1 uses offset 2. The single variant always uses offset 0.
- R7: A request accepted while idle starts the strobe one cycle later. rdStrobe (reqWrite=0) or wrStrobe (reqWrite=1) stays high for exactly the active count, then low for exactly the recovery count. Then done is high for one cycle.
- R8: A request raised while busy is ignored. The running strobe keeps its kind and length, and no transfer follows it.
- R9: A timing register write made during a transfer changes only the next transfer's timing.
- R10: In the single variant, offsets 2 and 3 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSlow | input | 1 | Strap: 1 when the bus runs at 33 MHz or less |
| regAddr | input | 2 | Register offset |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | 8 | Register write byte |
| regRdData | output | 8 | Register read byte (combinational) |
| reqValid | input | 1 | Transfer request |
| reqChannel | input | 1 | Channel of the request |
| reqDrive | input | 1 | Drive of the request |
| reqWrite | input | 1 | 1 = write strobe, 0 = read strobe |
| rdStrobe | output | 1 | Read strobe, active high |
| wrStrobe | output | 1 | Write strobe, active high |
| busy | output | 1 | Transfer in progress, through the done cycle |
| done | output | 1 | One-cycle pulse at the end of recovery |

## Verification
A wrong phase counter or a wrong timing snapshot shows up directly as a strobe that is one or more cycles too long or too short. It can also show up as a done pulse in the wrong cycle. Either is visible within the transfer in which the error occurs.

A wrong timer selection or a wrong decode table changes the lengths only for particular channel, drive and strap combinations. For that reason the stimulus sweeps all of those combinations with random timing bytes. A latch of the direction or of the accept condition that is updated while busy shows as a strobe of the other kind, or as an extra transfer right after done.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_RECOV  = 2'd2,
    ST_DONE   = 2'd3
  } pioState_t;

  typedef struct packed {
    logic capture;    // snapshot timing and load active count
    logic loadRecov;  // load recovery count
    logic countDown;  // decrement phase counter
  } ctrlStrobes_t;

  function automatic logic [CNT_W-1:0] decodeActive(input logic dual, input logic slow,
                                                    input logic [3:0] f);
    if (dual)      return CNT_W'(17) - {1'b0, f};
    else if (slow) return CNT_W'(9) - {2'b00, f[2:0]};
    else           return CNT_W'(8) - {2'b00, f[2:0]};
  endfunction

  function automatic logic [CNT_W-1:0] decodeRecov(input logic dual, input logic slow,
                                                   input logic [3:0] f);
    if (dual)      return (f >= 4'd14) ? CNT_W'(2) : CNT_W'(15) - {1'b0, f};
    else if (slow) return CNT_W'(15) - {1'b0, f};
    else           return CNT_W'(18) - {1'b0, f};
  endfunction
endpackage

// File: rtl/ide_pio_datapath.sv
module ide_pio_datapath
  import ide_pio_pkg::*;
#(
  parameter bit       DUAL_CHANNEL = 1'b1,
  parameter int       DATA_W       = 8,
  parameter logic [3:0] ID_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSlow,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              reqChannel,
  input  logic              reqDrive,
  input  ctrlStrobes_t      strobes,
  output logic              cntZero,
  output logic              recovZero
);
  localparam logic [DATA_W-1:0] TIMER_RST = DUAL_CHANNEL ? DATA_W'(8'h00) : DATA_W'(8'h08);
  localparam logic [DATA_W-1:0] CTRL_RST  = DATA_W'(8'h0F);

  logic [DATA_W-1:0] timer1, timer2, control, cfgByte, selTimer;
  logic [CNT_W-1:0]  phaseCnt, recSnap, decA, decR;

  always_ff @(posedge clk) begin
    if (!rstN)                          timer1 <= TIMER_RST;
    else if (regWrEn && regAddr == 2'd0) timer1 <= regWrData;
  end

  generate
    if (DUAL_CHANNEL) begin : g_dual
      always_ff @(posedge clk) begin
        if (!rstN) begin
          timer2  <= TIMER_RST;
          control <= CTRL_RST;
        end else if (regWrEn) begin
          if (regAddr == 2'd2) timer2  <= regWrData;
          if (regAddr == 2'd3) control <= regWrData;
        end
      end
      assign selTimer = control[0] ? (reqDrive ? timer2 : timer1)
                                   : (reqChannel ? timer2 : timer1);
    end else begin : g_single
      assign timer2   = '0;
      assign control  = '0;
      assign selTimer = timer1;
    end
  endgenerate

  assign cfgByte = {ID_CODE, DUAL_CHANNEL, busSlow, 2'b00};

  always_comb begin
    unique case (regAddr)
      2'd0:    regRdData = timer1;
      2'd1:    regRdData = cfgByte;
      2'd2:    regRdData = timer2;
      default: regRdData = control;
    endcase
  end

  assign decA = decodeActive(DUAL_CHANNEL, busSlow, selTimer[3:0]);
  assign decR = decodeRecov(DUAL_CHANNEL, busSlow, selTimer[7:4]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      recSnap  <= '0;
    end else if (strobes.capture) begin
      phaseCnt <= decA - CNT_W'(1);
      recSnap  <= decR;
    end else if (strobes.loadRecov) begin
      phaseCnt <= recSnap - CNT_W'(1);
    end else if (strobes.countDown) begin
      phaseCnt <= phaseCnt - CNT_W'(1);
    end
  end

  assign cntZero   = (phaseCnt == '0);
  assign recovZero = (recSnap == '0);

  // R9: a timer write outside capture leaves the running recovery snapshot alone
  a_r9_snapshot_hold: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !strobes.capture) |=> $stable(recSnap));

  // R7: loading recovery never happens with a zero count
  a_r7_recov_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRecov |-> !recovZero);
endmodule

// File: rtl/ide_pio_control.sv
module ide_pio_control
  import ide_pio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         cntZero,
  input  logic         recovZero,
  output ctrlStrobes_t strobes,
  output logic         rdStrobe,
  output logic         wrStrobe,
  output logic         busy,
  output logic         done
);
  pioState_t state, nextState;
  logic      wrLatch;

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobes.capture = 1'b1;
        nextState       = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (cntZero) begin
          if (recovZero) nextState = ST_DONE;
          else begin
            strobes.loadRecov = 1'b1;
            nextState         = ST_RECOV;
          end
        end else strobes.countDown = 1'b1;
      end
      ST_RECOV: begin
        if (cntZero) nextState = ST_DONE;
        else strobes.countDown = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wrLatch <= 1'b0;
    end else begin
      state <= nextState;
      if (strobes.capture) wrLatch <= reqWrite;
    end
  end

  assign rdStrobe = (state == ST_ACTIVE) && !wrLatch;
  assign wrStrobe = (state == ST_ACTIVE) && wrLatch;
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: the two strobes are never high together
  a_r7_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe));

  // R8: a strobe that continues keeps its kind
  a_r8_kind_stable: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe || rdStrobe) |=> ((wrStrobe || rdStrobe) -> $stable(wrStrobe)));

  // R7: done never overlaps a strobe
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(rdStrobe || wrStrobe));
endmodule

// File: rtl/ide_pio_strobe_timer.sv
module ide_pio_strobe_timer
  import ide_pio_pkg::*;
#(
  parameter bit         DUAL_CHANNEL = 1'b1,
  parameter logic [3:0] DUAL_ID      = 4'b1010,
  parameter logic [3:0] SINGLE_ID    = 4'b1100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSlow,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       reqValid,
  input  logic       reqChannel,
  input  logic       reqDrive,
  input  logic       reqWrite,
  output logic       rdStrobe,
  output logic       wrStrobe,
  output logic       busy,
  output logic       done
);
  localparam logic [3:0] ID_CODE = DUAL_CHANNEL ? DUAL_ID : SINGLE_ID;

  ctrlStrobes_t strobes;
  logic         cntZero, recovZero;

  ide_pio_datapath #(.DUAL_CHANNEL(DUAL_CHANNEL), .DATA_W(8), .ID_CODE(ID_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .busSlow(busSlow),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .reqChannel(reqChannel), .reqDrive(reqDrive),
    .strobes(strobes), .cntZero(cntZero), .recovZero(recovZero)
  );

  ide_pio_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .cntZero(cntZero), .recovZero(recovZero), .strobes(strobes),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .busy(busy), .done(done)
  );
endmodule

// File: tb/tb_ide_pio_strobe_timer.sv
module tb_ide_pio_strobe_timer;
  logic clk = 1'b0, rstN = 1'b0, busSlow = 1'b1;
  logic [1:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic reqValidD = 1'b0, reqValidS = 1'b0;
  logic reqChannel = 1'b0, reqDrive = 1'b0, reqWrite = 1'b0;
  logic [7:0] rdDataD, rdDataS;
  logic rdD, wrD, busyD, doneD, rdS, wrS, busyS, doneS;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ide_pio_strobe_timer #(.DUAL_CHANNEL(1'b1)) dut (
    .clk(clk), .rstN(rstN), .busSlow(busSlow), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(rdDataD), .reqValid(reqValidD),
    .reqChannel(reqChannel), .reqDrive(reqDrive), .reqWrite(reqWrite),
    .rdStrobe(rdD), .wrStrobe(wrD), .busy(busyD), .done(doneD));

  ide_pio_strobe_timer #(.DUAL_CHANNEL(1'b0)) dutSingle (
    .clk(clk), .rstN(rstN), .busSlow(busSlow), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(rdDataS), .reqValid(reqValidS),
    .reqChannel(reqChannel), .reqDrive(reqDrive), .reqWrite(reqWrite),
    .rdStrobe(rdS), .wrStrobe(wrS), .busy(busyS), .done(doneS));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int expActive(input bit dual, input bit slow, input logic [7:0] b);
    if (dual) return 17 - int'(b[3:0]);
    return slow ? 9 - int'(b[2:0]) : 8 - int'(b[2:0]);
  endfunction

  function automatic int expRecov(input bit dual, input bit slow, input logic [7:0] b);
    int r;
    if (dual) begin
      r = 15 - int'(b[7:4]);
      return (r < 2) ? 2 : r;
    end
    return slow ? 15 - int'(b[7:4]) : 18 - int'(b[7:4]);
  endfunction

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input bit single, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = single ? rdDataS : rdDataD;
  endtask

  function automatic logic selStrobe(input bit single, input bit wr);
    if (single) return wr ? wrS : rdS;
    return wr ? wrD : rdD;
  endfunction
  function automatic logic otherStrobe(input bit single, input bit wr);
    if (single) return wr ? rdS : wrS;
    return wr ? rdD : wrD;
  endfunction

  // Runs one transfer and measures it; mid=1 injects a request and a timer write during it.
  task automatic xfer(input bit single, input bit ch, input bit drv, input bit wr,
                      input int expA, input int expR, input bit mid, input logic [7:0] midByte,
                      input string tag);
    int hi = 0, lo = 0;
    @(negedge clk);
    reqChannel = ch; reqDrive = drv; reqWrite = wr;
    if (single) reqValidS = 1'b1; else reqValidD = 1'b1;
    @(negedge clk);
    reqValidS = 1'b0; reqValidD = 1'b0;
    while (selStrobe(single, wr) && hi < 40) begin
      if (otherStrobe(single, wr)) chk(1'b0, {tag, " R7 wrong strobe kind"}, 1, 0);
      hi++;
      if (mid && hi == 1) begin
        reqWrite = ~wr;
        if (single) reqValidS = 1'b1; else reqValidD = 1'b1;
        regAddr = 2'd0; regWrData = midByte; regWrEn = 1'b1;
      end
      @(negedge clk);
      if (mid && hi == 1) begin
        reqValidS = 1'b0; reqValidD = 1'b0; regWrEn = 1'b0;
      end
    end
    chk(hi == expA, {tag, " R7 active length"}, hi, expA);
    while (!(single ? doneS : doneD) && lo < 40) begin
      if (selStrobe(single, wr) || otherStrobe(single, wr))
        chk(1'b0, {tag, " R7 strobe in recovery"}, 1, 0);
      lo++;
      @(negedge clk);
    end
    chk(lo == expR, {tag, " R7 recovery length"}, lo, expR);
    @(negedge clk);
    chk((single ? doneS : doneD) == 1'b0, {tag, " R7 done one cycle"}, 1, 0);
    if (mid) begin
      repeat (3) begin
        @(negedge clk);
        chk(!(selStrobe(single, 1'b0) || selStrobe(single, 1'b1)),
            {tag, " R8 no transfer after busy request"}, 1, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, t1, t2;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(0, 2'd0, d); chk(d == 8'h00, "R1 timer1 reset", d, 8'h00);
    rdReg(0, 2'd2, d); chk(d == 8'h00, "R1 timer2 reset", d, 8'h00);
    rdReg(0, 2'd3, d); chk(d == 8'h0F, "R1 control reset", d, 8'h0F);
    rdReg(1, 2'd0, d); chk(d == 8'h08, "R1 single timer reset", d, 8'h08);
    chk(!(rdD || wrD || busyD || rdS || wrS || busyS), "R1 idle outputs", 0, 0);

    // R3 configuration register
    rdReg(0, 2'd1, d); chk(d == 8'hAC, "R3 dual cfg slow", d, 8'hAC);
    rdReg(1, 2'd1, d); chk(d == 8'hC4, "R3 single cfg slow", d, 8'hC4);
    busSlow = 1'b0;
    wrReg(2'd1, 8'h33);
    rdReg(0, 2'd1, d); chk(d == 8'hA8, "R3 dual cfg fast after write", d, 8'hA8);
    rdReg(1, 2'd1, d); chk(d == 8'hC0, "R3 single cfg fast", d, 8'hC0);
    busSlow = 1'b1;

    // R1 slowest default timing in dual mode
    xfer(0, 0, 0, 0, 17, 15, 0, 8'h00, "reset-timing R1");

    // R2 readback and R10 single upper offsets
    wrReg(2'd0, 8'h5A); wrReg(2'd2, 8'hA5);
    rdReg(0, 2'd0, d); chk(d == 8'h5A, "R2 timer1 readback", d, 8'h5A);
    rdReg(0, 2'd2, d); chk(d == 8'hA5, "R2 timer2 readback", d, 8'hA5);
    wrReg(2'd3, 8'h0E);
    rdReg(1, 2'd2, d); chk(d == 8'h00, "R10 single offset2", d, 0);
    rdReg(1, 2'd3, d); chk(d == 8'h00, "R10 single offset3", d, 0);

    // R4 corners, R6 mapping (control bit0 = 0 after 0x0E)
    wrReg(2'd0, 8'h0F); wrReg(2'd2, 8'hF0);
    xfer(0, 0, 1, 1, 2, 15, 0, 8'h00, "R4 min active ch0");
    xfer(0, 1, 0, 0, 17, 2, 0, 8'h00, "R4 recovery floor R6 ch1");
    wrReg(2'd3, 8'h0F);
    xfer(0, 1, 0, 1, 2, 15, 0, 8'h00, "R6 primary-only drive0");
    xfer(0, 0, 1, 0, 17, 2, 0, 8'h00, "R6 primary-only drive1");

    // R5 single decode corners
    wrReg(2'd0, 8'h0F);
    xfer(1, 0, 0, 0, 2, 15, 0, 8'h00, "R5 slow min active");
    wrReg(2'd0, 8'hF8);
    xfer(1, 0, 0, 1, 9, 0, 0, 8'h00, "R5 slow zero recovery");
    busSlow = 1'b0;
    xfer(1, 1, 1, 0, 8, 3, 0, 8'h00, "R5 fast min recovery");
    wrReg(2'd0, 8'h0F);
    xfer(1, 0, 0, 1, 1, 18, 0, 8'h00, "R5 fast max recovery");
    busSlow = 1'b1;

    // R8 and R9: busy request and mid-transfer timer write
    wrReg(2'd3, 8'h0E);
    wrReg(2'd0, 8'h34);
    xfer(0, 0, 0, 0, 13, 12, 1, 8'h71, "R8 R9 mid");
    xfer(0, 0, 0, 1, 16, 8, 0, 8'h00, "R9 next transfer");

    // randomized sweep
    for (int i = 0; i < 40; i++) begin
      bit pMode, ch, drv, wr;
      logic [7:0] use1;
      t1 = 8'($urandom); t2 = 8'($urandom);
      pMode = 1'($urandom); ch = 1'($urandom); drv = 1'($urandom); wr = 1'($urandom);
      wrReg(2'd0, t1); wrReg(2'd2, t2); wrReg(2'd3, {7'b0000111, pMode});
      rdReg(0, 2'd2, d); chk(d == t2, "R2 random readback", d, t2);
      use1 = pMode ? (drv ? t2 : t1) : (ch ? t2 : t1);
      xfer(0, ch, drv, wr, expActive(1, 0, use1), expRecov(1, 0, use1), 0, 8'h00,
           "random dual R4 R6 R7");
      if (i % 3 == 0) begin
        busSlow = 1'($urandom);
        xfer(1, ch, drv, wr, expActive(0, busSlow, t1), expRecov(0, busSlow, t1), 0, 8'h00,
             "random single R5 R7");
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule